// File: doc/BRIEF.md
# Capability Chain Walker

This engine searches a device's configuration space for a capability with a given ID. On a start pulse it walks one of two linked lists held in that space. The first is the standard chain: 16-bit entries in the first 256 bytes, rooted at a list register. The second is the extended chain: 32-bit headers from byte 256 upward. It follows next pointers until the ID is matched or the walk has to stop. The configuration space lives outside the engine. The engine reaches it only through a request/valid read port that returns one aligned 32-bit word per request, after any latency of one cycle or more.

A resume mode supports finding later instances of the same ID. The caller passes the offset returned by an earlier search. The walk starts at that entry, ignores a match there, and carries on along the chain. A hard limit on the number of entries examined ends any walk over a broken or circular chain.

When the walk ends, the engine pulses a done strobe for one cycle, together with a found flag and the byte offset of the matching entry. These results stay on the outputs until the next search starts.

Top module: `capwalk_engine`

## Requirements
- R1: A standard search with resume low first reads the word at byte 0x34. Bits [7:0] of that word, with bits [1:0] cleared, give the first entry's offset. In each entry word, bits [7:0] are the capability ID and bits [15:8] are the next pointer, with bits [1:0] cleared. When the ID equals target_id_i[7:0], the engine reports found with that entry's offset.
- R2: In standard mode the walk ends with not-found when the first-entry pointer is zero or when an entry's next pointer is zero.
- R3: In standard mode an entry whose ID is above STD_MAX_ID (default 0x15) ends the walk with not-found at once. No entry after it is read.
- R4: An extended search with resume low begins at byte 256. In each header, bits [15:0] hold the ID, compared with all 16 bits of target_id_i, and bits [31:20] hold the next offset, with bits [1:0] cleared. An extended match is always reported at an offset of 256 or more.
- R5: In extended mode, when the first header read is all zeros, the search ends with not-found after that single read, whatever the target ID.
- R6: In extended mode a next offset below 256 ends the walk with not-found.
- R7: A walk examines at most 480 extended headers or 48 standard entries. A circular chain therefore ends with not-found after exactly that many header reads, plus the one list-register read in standard mode.
- R8: With resume_i high, the walk starts at resume_off_i with bits [1:0] cleared, in either mode. A match at that offset is skipped and the walk continues along the chain.
- R9: done_o is high for exactly one cycle per search. On not-found, offset_o is 0 and found_o is low. found_o and offset_o hold their values until the next accepted start.
- R10: Each read is a single-cycle rd_req_o pulse with a 4-byte-aligned rd_addr_o. The engine waits any number of cycles for rd_valid_i before it continues.
- R11: A start_i pulse while the engine is busy is ignored. The running search finishes with its original target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (accepted when idle) |
| ext_mode_i | input | 1 | 0 walks the standard chain, 1 the extended chain |
| resume_i | input | 1 | Resume from resume_off_i and skip a match there |
| resume_off_i | input | ADDR_W | Byte offset to resume from |
| target_id_i | input | 16 | Capability ID searched for (standard uses bits [7:0]) |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | ADDR_W | Aligned byte address of the read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data word |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| found_o | output | 1 | Capability found |
| offset_o | output | ADDR_W | Byte offset of the match, 0 if none |

## Verification
On every cycle the assertions check the following:
- the done strobe lasts one cycle;
- a not-found result carries offset zero;
- read requests are single-cycle and aligned;
- extended matches never sit below byte 256;
- the iteration counter never wraps;
- a start pulse during a busy walk leaves the latched target alone.

The bench's scenarios are the only way to show the walk itself. They check which entry is chosen, each stop condition, the skip-at-start rule, and the exact number of reads a circular chain costs. They use directed memory images served with several read latencies.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_REQ  = 2'd1,
    WALK_WAIT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/capwalk_decode.sv
// Combinational header interpretation for both chain formats.
module capwalk_decode #(
  parameter int          ADDR_W     = 12,
  parameter int          STD_BYTES  = 256,
  parameter logic [7:0]  STD_MAX_ID = 8'h15
) (
  input  logic              ext_i,
  input  logic [31:0]       hdr_i,
  input  logic [ADDR_W-1:0] pos_i,
  input  logic [ADDR_W-1:0] skip_pos_i,
  input  logic              skip_en_i,
  input  logic [15:0]       tgt_i,
  output logic              hit_o,
  output logic              bad_id_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              end_o
);
  logic id_eq;
  logic at_skip;
  logic unused_hdr_bits;

  assign unused_hdr_bits = ^{hdr_i[21:16], hdr_i[9:8]};
  assign at_skip         = skip_en_i && (pos_i == skip_pos_i);

  always_comb begin
    if (ext_i) begin
      id_eq    = (hdr_i[15:0] == tgt_i);
      bad_id_o = 1'b0;
      next_o   = ADDR_W'({hdr_i[31:22], 2'b00});
      end_o    = (next_o < ADDR_W'(STD_BYTES));
    end else begin
      id_eq    = (hdr_i[7:0] == tgt_i[7:0]);
      bad_id_o = (hdr_i[7:0] > STD_MAX_ID);
      next_o   = ADDR_W'({hdr_i[15:10], 2'b00});
      end_o    = (next_o == '0);
    end
    hit_o = id_eq && !at_skip;
  end
endmodule

// File: rtl/capwalk_ttl.sv
// Remaining-entry budget for one walk.
module capwalk_ttl #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == W'(1));

  // R7
  ttl_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (cnt_q > W'(1)));
endmodule

// File: rtl/capwalk_engine.sv
module capwalk_engine #(
  parameter int         CFG_BYTES     = 4096,
  parameter int         STD_BYTES     = 256,
  parameter int         STD_HDR_BYTES = 64,
  parameter int         LIST_ADDR     = 52,
  parameter logic [7:0] STD_MAX_ID    = 8'h15,
  localparam int        ADDR_W        = $clog2(CFG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_mode_i,
  input  logic              resume_i,
  input  logic [ADDR_W-1:0] resume_off_i,
  input  logic [15:0]       target_id_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] offset_o
);
  import capwalk_pkg::*;

  localparam int EXT_TTL = (CFG_BYTES - STD_BYTES) / 8;
  localparam int STD_TTL = (STD_BYTES - STD_HDR_BYTES) / 4;
  localparam int TTL_W   = $clog2(EXT_TTL + 1);
  localparam logic [ADDR_W-1:0] LIST_A = ADDR_W'(LIST_ADDR);
  localparam logic [ADDR_W-1:0] EXT_A  = ADDR_W'(STD_BYTES);

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] pos_q, pos_d, skip_pos_q, skip_pos_d, off_q, off_d;
  logic [15:0]       tgt_q, tgt_d;
  logic              ext_q, ext_d, skip_en_q, skip_en_d, list_q, list_d;
  logic              first_q, first_d, done_q, done_d, found_q, found_d;
  logic              ttl_load, ttl_dec, ttl_last;
  logic              hit, bad_id, chain_end;
  logic [ADDR_W-1:0] next_ptr, resume_al, list_ptr;
  logic              unused_resume_lsb;

  assign resume_al         = {resume_off_i[ADDR_W-1:2], 2'b00};
  assign unused_resume_lsb = ^resume_off_i[1:0];
  assign list_ptr          = ADDR_W'({rd_data_i[7:2], 2'b00});

  capwalk_decode #(
    .ADDR_W(ADDR_W), .STD_BYTES(STD_BYTES), .STD_MAX_ID(STD_MAX_ID)
  ) u_decode (
    .ext_i(ext_q), .hdr_i(rd_data_i), .pos_i(pos_q),
    .skip_pos_i(skip_pos_q), .skip_en_i(skip_en_q), .tgt_i(tgt_q),
    .hit_o(hit), .bad_id_o(bad_id), .next_o(next_ptr), .end_o(chain_end)
  );

  capwalk_ttl #(.W(TTL_W)) u_ttl (
    .clk(clk), .rst_n(rst_n), .load_i(ttl_load),
    .load_val_i(ext_mode_i ? TTL_W'(EXT_TTL) : TTL_W'(STD_TTL)),
    .dec_i(ttl_dec), .last_o(ttl_last)
  );

  always_comb begin
    state_d    = state_q;
    pos_d      = pos_q;
    skip_pos_d = skip_pos_q;
    skip_en_d  = skip_en_q;
    tgt_d      = tgt_q;
    ext_d      = ext_q;
    list_d     = list_q;
    first_d    = first_q;
    found_d    = found_q;
    off_d      = off_q;
    done_d     = 1'b0;
    ttl_load   = 1'b0;
    ttl_dec    = 1'b0;
    case (state_q)
      WALK_IDLE: if (start_i) begin
        ext_d      = ext_mode_i;
        tgt_d      = target_id_i;
        skip_en_d  = resume_i;
        skip_pos_d = resume_al;
        first_d    = 1'b1;
        found_d    = 1'b0;
        off_d      = '0;
        ttl_load   = 1'b1;
        list_d     = !ext_mode_i && !resume_i;
        if (resume_i)        pos_d = resume_al;
        else if (ext_mode_i) pos_d = EXT_A;
        else                 pos_d = LIST_A;
        state_d    = WALK_REQ;
      end
      WALK_REQ: state_d = WALK_WAIT;
      WALK_WAIT: if (rd_valid_i) begin
        if (list_q) begin
          if (list_ptr == '0) begin
            done_d  = 1'b1;
            state_d = WALK_IDLE;
          end else begin
            pos_d   = list_ptr;
            list_d  = 1'b0;
            state_d = WALK_REQ;
          end
        end else if ((ext_q && first_q && rd_data_i == '0) || bad_id) begin
          done_d  = 1'b1;
          state_d = WALK_IDLE;
        end else if (hit) begin
          done_d  = 1'b1;
          found_d = 1'b1;
          off_d   = pos_q;
          state_d = WALK_IDLE;
        end else if (ttl_last || chain_end) begin
          done_d  = 1'b1;
          state_d = WALK_IDLE;
        end else begin
          pos_d   = next_ptr;
          first_d = 1'b0;
          ttl_dec = 1'b1;
          state_d = WALK_REQ;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WALK_IDLE;
      pos_q      <= '0;
      skip_pos_q <= '0;
      skip_en_q  <= 1'b0;
      tgt_q      <= '0;
      ext_q      <= 1'b0;
      list_q     <= 1'b0;
      first_q    <= 1'b0;
      found_q    <= 1'b0;
      off_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      pos_q      <= pos_d;
      skip_pos_q <= skip_pos_d;
      skip_en_q  <= skip_en_d;
      tgt_q      <= tgt_d;
      ext_q      <= ext_d;
      list_q     <= list_d;
      first_q    <= first_d;
      found_q    <= found_d;
      off_q      <= off_d;
      done_q     <= done_d;
    end
  end

  assign rd_req_o  = (state_q == WALK_REQ);
  assign rd_addr_o = pos_q;
  assign busy_o    = (state_q != WALK_IDLE);
  assign done_o    = done_q;
  assign found_o   = found_q;
  assign offset_o  = off_q;

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  miss_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> (offset_o == '0));
  // R10
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  // R10
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o[1:0] == 2'b00));
  // R4
  ext_hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o && ext_q) |-> (offset_o >= EXT_A));
  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tgt_q));
endmodule

// File: tb/capwalk_engine_tb_top.sv
module capwalk_engine_tb_top;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, ext_mode_i = 1'b0, resume_i = 1'b0;
  logic [AW-1:0] resume_off_i = '0;
  logic [15:0]   target_id_i = '0;
  logic          rd_req_o, rd_valid_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [31:0]   rd_data_i = '0;
  logic          busy_o, done_o, found_o;
  logic [AW-1:0] offset_o;

  int total = 0, fails = 0, cycles = 0, rd_cnt = 0, lat = 1, pend = 0;
  logic [AW-1:0] addr_l = '0;
  logic [31:0]   mem [0:1023];
  logic          r_found;
  logic [AW-1:0] r_off;
  int            r_reads;

  always #10 clk = ~clk;

  capwalk_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_mode_i(ext_mode_i),
    .resume_i(resume_i), .resume_off_i(resume_off_i), .target_id_i(target_id_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .found_o(found_o), .offset_o(offset_o)
  );

  // configuration-space model with programmable latency
  always @(posedge clk) begin
    rd_valid_i <= 1'b0;
    if (rd_req_o) begin
      rd_cnt <= rd_cnt + 1;
      pend   <= lat;
      addr_l <= rd_addr_o;
    end else if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= mem[addr_l[AW-1:2]];
      end
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d expected <= 150000 cycles", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_mem;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic put(input int byte_addr, input logic [31:0] v);
    mem[byte_addr / 4] = v;
  endtask

  task automatic pulse_start(input logic ext, input logic res,
                             input logic [AW-1:0] off, input logic [15:0] id);
    @(negedge clk);
    ext_mode_i = ext; resume_i = res; resume_off_i = off; target_id_i = id;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // waits for done, captures result, checks the strobe drops and results hold
  task automatic wait_done(input string req, input int rd0);
    int n = 0;
    while (!done_o && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done seen", done_o, 1'b1);
    r_found = found_o;
    r_off   = offset_o;
    @(negedge clk);
    r_reads = rd_cnt - rd0;
    chk("R9", "done single cycle", done_o, 1'b0);
    chk("R9", "found held", found_o, r_found);
    chk("R9", "offset held", offset_o, r_off);
  endtask

  task automatic search(input string req, input logic ext, input logic res,
                        input logic [AW-1:0] off, input logic [15:0] id);
    int rd0 = rd_cnt;
    pulse_start(ext, res, off, id);
    wait_done(req, rd0);
  endtask

  task automatic load_std_chain;
    clr_mem();
    put(52, 32'h0000_0040);
    put(32'h40, {16'h0, 8'h50, 8'h01});
    put(32'h50, {16'h0, 8'h73, 8'h05});   // next pointer with low bits set
    put(32'h70, {16'h0, 8'h00, 8'h10});
  endtask

  task automatic t_reset;
    chk("R9", "reset done", done_o, 1'b0);
    chk("R9", "reset found", found_o, 1'b0);
    chk("R9", "reset offset", offset_o, 0);
    chk("R10", "reset req", rd_req_o, 1'b0);
    chk("R11", "reset busy", busy_o, 1'b0);
  endtask

  task automatic t_std_find;
    load_std_chain();
    foreach (lat_set[k]) begin
      lat = lat_set[k];
      search("R1", 1'b0, 1'b0, '0, 16'h0010);
      chk("R1", "std found last", r_found, 1'b1);
      chk("R1", "std offset last", r_off, 12'h070);
      chk("R10", "std read count", r_reads, 4);
      search("R1", 1'b0, 1'b0, '0, 16'h0005);
      chk("R1", "std offset mid", r_off, 12'h050);
    end
    lat = 1;
  endtask

  int lat_set [3] = '{1, 3, 7};

  task automatic t_std_end;
    load_std_chain();
    search("R2", 1'b0, 1'b0, '0, 16'h0011);
    chk("R2", "std miss found", r_found, 1'b0);
    chk("R9", "std miss offset", r_off, 0);
    put(52, 32'h0000_0003);               // masks to zero
    search("R2", 1'b0, 1'b0, '0, 16'h0001);
    chk("R2", "empty list found", r_found, 1'b0);
    chk("R2", "empty list reads", r_reads, 1);
  endtask

  task automatic t_std_bad_id;
    load_std_chain();
    put(32'h50, {16'h0, 8'h70, 8'h30});
    search("R3", 1'b0, 1'b0, '0, 16'h0010);
    chk("R3", "bad id found", r_found, 1'b0);
    chk("R3", "bad id reads", r_reads, 3);
  endtask

  task automatic load_ext_chain;
    clr_mem();
    put(256, {12'h148, 4'h1, 16'h0001});
    put(32'h148, {12'h203, 4'h2, 16'h000B});
    put(32'h200, {12'h000, 4'h1, 16'h0001});
  endtask

  task automatic t_ext;
    load_ext_chain();
    lat = 2;
    search("R4", 1'b1, 1'b0, '0, 16'h000B);
    chk("R4", "ext found", r_found, 1'b1);
    chk("R4", "ext offset", r_off, 12'h148);
    search("R4", 1'b1, 1'b0, '0, 16'h0001);
    chk("R4", "ext first offset", r_off, 12'h100);
    search("R8", 1'b1, 1'b1, 12'h100, 16'h0001);
    chk("R8", "ext next found", r_found, 1'b1);
    chk("R8", "ext next offset", r_off, 12'h200);
    search("R6", 1'b1, 1'b0, '0, 16'h0019);
    chk("R6", "ext chain end found", r_found, 1'b0);
    chk("R6", "ext chain end reads", r_reads, 3);
    put(256, {12'h0FC, 4'h1, 16'h0001});
    search("R6", 1'b1, 1'b0, '0, 16'h000B);
    chk("R6", "ext low next found", r_found, 1'b0);
    chk("R6", "ext low next reads", r_reads, 1);
    lat = 1;
  endtask

  task automatic t_ext_zero;
    clr_mem();
    put(32'h104, {12'h000, 4'h0, 16'h0000});
    search("R5", 1'b1, 1'b0, '0, 16'h0000);
    chk("R5", "zero header found", r_found, 1'b0);
    chk("R5", "zero header reads", r_reads, 1);
  endtask

  task automatic t_loops;
    clr_mem();
    put(256, {12'h100, 4'h1, 16'h0001});
    search("R7", 1'b1, 1'b0, '0, 16'h0002);
    chk("R7", "ext loop found", r_found, 1'b0);
    chk("R7", "ext loop reads", r_reads, 480);
    put(52, 32'h0000_0040);
    put(32'h40, {16'h0, 8'h40, 8'h01});
    search("R7", 1'b0, 1'b0, '0, 16'h0002);
    chk("R7", "std loop found", r_found, 1'b0);
    chk("R7", "std loop reads", r_reads, 49);
  endtask

  task automatic t_std_resume;
    clr_mem();
    put(52, 32'h0000_0040);
    put(32'h40, {16'h0, 8'h50, 8'h01});
    put(32'h50, {16'h0, 8'h70, 8'h05});
    put(32'h70, {16'h0, 8'h00, 8'h01});
    search("R8", 1'b0, 1'b1, 12'h042, 16'h0001);
    chk("R8", "std resume found", r_found, 1'b1);
    chk("R8", "std resume offset", r_off, 12'h070);
  endtask

  task automatic t_busy_start;
    int rd0;
    load_std_chain();
    lat = 3;
    rd0 = rd_cnt;
    pulse_start(1'b0, 1'b0, '0, 16'h0010);
    repeat (3) @(negedge clk);
    chk("R11", "busy during walk", busy_o, 1'b1);
    ext_mode_i = 1'b1; target_id_i = 16'h0001; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R11", rd0);
    chk("R11", "busy start found", r_found, 1'b1);
    chk("R11", "busy start offset", r_off, 12'h070);
    chk("R11", "busy start reads", r_reads, 4);
    lat = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_std_find();
    t_std_end();
    t_std_bad_id();
    t_ext();
    t_ext_zero();
    t_loops();
    t_std_resume();
    t_busy_start();
    report();
    $finish;
  end
endmodule